// File: doc/BRIEF.md
# Descriptor Ring Walker

This block is the memory-side engine of one DMA direction. It steps through a circular list of four-word buffer descriptors held in system memory. For each descriptor it reads the ownership word. When the device owns the descriptor, it reads the control, buffer-address and link words and offers the buffer to a data mover. When the mover reports completion, the walker writes a status word back over word 0. That write carries the byte count and an error summary and hands ownership back to the host. The walker then moves on to the next descriptor.

Software sets up the ring, places the address of the first descriptor on the base input and pulses start. When the walker meets a descriptor the host still owns, it parks and raises an idle flag. Software gives descriptors back to the device and pulses a poll-demand input, and the walker then re-reads the descriptor it parked on. The next descriptor is chosen in this order. An end-of-ring flag sends the walker back to the base. Otherwise a chained flag makes it follow the link word. Failing both, it takes the descriptor that sits directly after the current one.

Top module: `dring_walker`

## Requirements
- R1: After reset no memory request, buffer offer, idle flag or done pulse is active, and nothing is requested until start_i is pulsed. Start latches base_addr_i as both the ring base and the current descriptor address.
- R2: The first access to a descriptor reads word 0 at the descriptor address. If bit 31 of that word is 0 (host owns it), the walker issues no further requests, drives idle_o high, and stays there until poll_i is pulsed. It then reads word 0 at the same address again.
- R3: If bit 31 of word 0 is 1, the walker reads words 1, 2 and 3 at offsets +4, +8 and +12, in that order. It then offers buf_addr_o equal to word 2 and buf_size_o equal to word 1 bits 10:0, and holds both until buf_ready_i.
- R4: After done_i, the walker writes one word to the descriptor address. In that word, bit 31 is 0, bits 26:16 hold done_count_i, bit 15 holds done_err_i, and all other bits are 0. desc_done_o is high for exactly the cycle after the write is acknowledged.
- R5: If word 1 bit 25 (end of ring) is set, the next descriptor is at the ring base. Word 3 and bit 24 are ignored in that case.
- R6: If word 1 bit 24 (chained) is set and bit 25 is clear, the next descriptor address is word 3.
- R7: If both bit 24 and bit 25 are clear, the next descriptor is at the current address plus 16.
- R8: A descriptor whose size field is 0 is never offered to the data mover. It is written back at once with count 0 and error 0, and the walker then advances.
- R9: A memory request holds its address, direction and write data unchanged until mem_ack_i is seen. Read data is taken in the cycle the acknowledge is high.
- R10: start_i has no effect once the walker has left the stopped state. The base latched at the first start stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured only when stopped |
| base_addr_i | input | AW | Address of the first descriptor |
| poll_i | input | 1 | Poll demand, resumes a parked walker |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| buf_valid_o | output | 1 | Buffer offered to the data mover |
| buf_addr_o | output | AW | Buffer address |
| buf_size_o | output | SIZE_W | Usable buffer length in bytes |
| buf_ready_i | input | 1 | Data mover takes the buffer |
| done_i | input | 1 | Buffer finished |
| done_count_i | input | SIZE_W | Bytes transferred |
| done_err_i | input | 1 | Error summary for the buffer |
| idle_o | output | 1 | Parked on a host-owned descriptor |
| desc_done_o | output | 1 | One-cycle pulse per descriptor written back |

## Verification
The bench targets the choice of the next descriptor. The ring it builds uses a chained hop to an address that is not adjacent, then an unchained step to the adjacent descriptor, then an end-of-ring descriptor whose link word points somewhere else. A walker that ranked the flags wrongly or ignored a link would read the wrong address at once. A zero-size descriptor is placed so that a walker which offered it to the mover, or wrote a non-zero status, would show an unexpected handshake or write data. The parked state is re-entered twice, once through an end-of-ring descriptor that also has size zero, to catch a walker that keeps requesting while idle or resumes at a different address after poll. A second start with a different base is sent mid-run; a walker that honoured it would wrap to the wrong base. Memory latency varies from request to request, so a walker that drops or changes a pending request is exposed.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int WORD_W     = 32;
  localparam int OWN_BIT    = 31;
  localparam int EOR_BIT    = 25;
  localparam int CHAIN_BIT  = 24;
  localparam int CNT_LSB    = 16;
  localparam int ERR_BIT    = 15;
  localparam int DESC_BYTES = 16;

  typedef enum logic [2:0] {
    ST_STOP,
    ST_READ,
    ST_SUSP,
    ST_GIVE,
    ST_BUSY,
    ST_WB
  } walk_state_e;
endpackage

// File: rtl/dring_decode.sv
module dring_decode
  import dring_pkg::*;
#(
  parameter int SIZE_W = 11
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              own_o,
  output logic              eor_o,
  output logic              chain_o,
  output logic [SIZE_W-1:0] size_o
);
  logic unused_bits;

  assign own_o       = word_i[OWN_BIT];
  assign eor_o       = word_i[EOR_BIT];
  assign chain_o     = word_i[CHAIN_BIT];
  assign size_o      = word_i[SIZE_W-1:0];
  assign unused_bits = ^{word_i[30:26], word_i[23:SIZE_W]};
endmodule

// File: rtl/dring_next.sv
module dring_next
  import dring_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] link_i,
  input  logic          eor_i,
  input  logic          chain_i,
  output logic [AW-1:0] next_o
);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  // end of ring outranks the link word
  always_comb begin
    if (eor_i)        next_o = base_i;
    else if (chain_i) next_o = link_i;
    else              next_o = cur_i + STEP;
  end
endmodule

// File: rtl/dring_status.sv
module dring_status
  import dring_pkg::*;
#(
  parameter int SIZE_W = 11
) (
  input  logic [SIZE_W-1:0] cnt_i,
  input  logic              err_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o                       = '0;
    word_o[CNT_LSB +: SIZE_W]    = cnt_i;
    word_o[ERR_BIT]              = err_i;
  end
endmodule

// File: rtl/dring_ctrl.sv
module dring_ctrl
  import dring_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     base_addr_i,
  input  logic              poll_i,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              rd_own_i,
  input  logic              rd_eor_i,
  input  logic              rd_chain_i,
  input  logic [SIZE_W-1:0] rd_size_i,
  input  logic [AW-1:0]     next_i,
  input  logic [WORD_W-1:0] wb_word_i,
  input  logic              buf_ready_i,
  input  logic              done_i,
  input  logic [SIZE_W-1:0] done_count_i,
  input  logic              done_err_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [AW-1:0]     cur_o,
  output logic [AW-1:0]     base_o,
  output logic [AW-1:0]     link_o,
  output logic              eor_o,
  output logic              chain_o,
  output logic [SIZE_W-1:0] cnt_o,
  output logic              err_o,
  output logic              buf_valid_o,
  output logic [AW-1:0]     buf_addr_o,
  output logic [SIZE_W-1:0] buf_size_o,
  output logic              idle_o,
  output logic              desc_done_o
);
  walk_state_e       state_q;
  logic [1:0]        wd_q;
  logic [AW-1:0]     cur_q, base_q, bufa_q, link_q;
  logic              eor_q, chain_q, err_q, done_q;
  logic [SIZE_W-1:0] size_q, cnt_q;
  logic unused_rdata;

  assign unused_rdata = ^mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STOP;
      wd_q    <= '0;
      cur_q   <= '0;
      base_q  <= '0;
      bufa_q  <= '0;
      link_q  <= '0;
      eor_q   <= 1'b0;
      chain_q <= 1'b0;
      size_q  <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_STOP: if (start_i) begin
          base_q  <= base_addr_i;
          cur_q   <= base_addr_i;
          wd_q    <= '0;
          state_q <= ST_READ;
        end
        ST_READ: if (mem_ack_i) begin
          unique case (wd_q)
            2'd0: begin
              if (!rd_own_i) state_q <= ST_SUSP;
              else           wd_q    <= 2'd1;
            end
            2'd1: begin
              eor_q   <= rd_eor_i;
              chain_q <= rd_chain_i;
              size_q  <= rd_size_i;
              wd_q    <= 2'd2;
            end
            2'd2: begin
              bufa_q <= mem_rdata_i[AW-1:0];
              wd_q   <= 2'd3;
            end
            default: begin
              link_q <= mem_rdata_i[AW-1:0];
              wd_q   <= 2'd0;
              if (size_q == '0) begin
                cnt_q   <= '0;
                err_q   <= 1'b0;
                state_q <= ST_WB;
              end else begin
                state_q <= ST_GIVE;
              end
            end
          endcase
        end
        ST_SUSP: if (poll_i) state_q <= ST_READ;
        ST_GIVE: if (buf_ready_i) state_q <= ST_BUSY;
        ST_BUSY: if (done_i) begin
          cnt_q   <= done_count_i;
          err_q   <= done_err_i;
          state_q <= ST_WB;
        end
        ST_WB: if (mem_ack_i) begin
          cur_q   <= next_i;
          done_q  <= 1'b1;
          state_q <= ST_READ;
        end
        default: state_q <= ST_STOP;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WB);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = cur_q + AW'({wd_q, 2'b00});
  assign mem_wdata_o = wb_word_i;
  assign cur_o       = cur_q;
  assign base_o      = base_q;
  assign link_o      = link_q;
  assign eor_o       = eor_q;
  assign chain_o     = chain_q;
  assign cnt_o       = cnt_q;
  assign err_o       = err_q;
  assign buf_valid_o = (state_q == ST_GIVE);
  assign buf_addr_o  = bufa_q;
  assign buf_size_o  = size_q;
  assign idle_o      = (state_q == ST_SUSP);
  assign desc_done_o = done_q;

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r4_wb_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[OWN_BIT]);

  a_r4_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_done_o |-> $past(mem_req_o && mem_we_o && mem_ack_i));

  a_r2_parked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mem_req_o && !buf_valid_o);

  a_r8_no_empty_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_valid_o |-> buf_size_o != '0);

  a_r3_offer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_valid_o && !buf_ready_i |=> buf_valid_o && $stable(buf_addr_o)
                                    && $stable(buf_size_o));

  a_r5_wrap_to_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i && eor_q |=> mem_addr_o == base_q);

  a_r10_base_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_STOP && $past(state_q) != ST_STOP |-> $stable(base_q));
endmodule

// File: rtl/dring_walker.sv
module dring_walker
  import dring_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SIZE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     base_addr_i,
  input  logic              poll_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              buf_valid_o,
  output logic [AW-1:0]     buf_addr_o,
  output logic [SIZE_W-1:0] buf_size_o,
  input  logic              buf_ready_i,
  input  logic              done_i,
  input  logic [SIZE_W-1:0] done_count_i,
  input  logic              done_err_i,
  output logic              idle_o,
  output logic              desc_done_o
);
  logic              rd_own, rd_eor, rd_chain;
  logic [SIZE_W-1:0] rd_size;
  logic [AW-1:0]     cur, base, link, next;
  logic              eor, chain, err;
  logic [SIZE_W-1:0] cnt;
  logic [WORD_W-1:0] wb_word;

  dring_decode #(.SIZE_W(SIZE_W)) u_decode (
    .word_i (mem_rdata_i),
    .own_o  (rd_own),
    .eor_o  (rd_eor),
    .chain_o(rd_chain),
    .size_o (rd_size)
  );

  dring_next #(.AW(AW)) u_next (
    .cur_i  (cur),
    .base_i (base),
    .link_i (link),
    .eor_i  (eor),
    .chain_i(chain),
    .next_o (next)
  );

  dring_status #(.SIZE_W(SIZE_W)) u_status (
    .cnt_i (cnt),
    .err_i (err),
    .word_o(wb_word)
  );

  dring_ctrl #(.AW(AW), .SIZE_W(SIZE_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .base_addr_i (base_addr_i),
    .poll_i      (poll_i),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .rd_own_i    (rd_own),
    .rd_eor_i    (rd_eor),
    .rd_chain_i  (rd_chain),
    .rd_size_i   (rd_size),
    .next_i      (next),
    .wb_word_i   (wb_word),
    .buf_ready_i (buf_ready_i),
    .done_i      (done_i),
    .done_count_i(done_count_i),
    .done_err_i  (done_err_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .cur_o       (cur),
    .base_o      (base),
    .link_o      (link),
    .eor_o       (eor),
    .chain_o     (chain),
    .cnt_o       (cnt),
    .err_o       (err),
    .buf_valid_o (buf_valid_o),
    .buf_addr_o  (buf_addr_o),
    .buf_size_o  (buf_size_o),
    .idle_o      (idle_o),
    .desc_done_o (desc_done_o)
  );
endmodule

// File: tb/dring_walker_test.sv
module dring_walker_test;
  localparam int AW = 32;
  localparam int SW = 11;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_addr_i = '0;
  logic          poll_i = 1'b0;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o;
  logic          mem_ack_i = 1'b0;
  logic [31:0]   mem_rdata_i = '0;
  logic          buf_valid_o;
  logic [AW-1:0] buf_addr_o;
  logic [SW-1:0] buf_size_o;
  logic          buf_ready_i = 1'b0;
  logic          done_i = 1'b0;
  logic [SW-1:0] done_count_i = '0;
  logic          done_err_i = 1'b0;
  logic          idle_o, desc_done_o;

  always #10 clk_i = ~clk_i;

  dring_walker #(.AW(AW), .SIZE_W(SW)) uut (.*);

  typedef struct {
    int          kind;   // 0 read, 1 write, 2 offer
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } item_t;

  item_t       exp_q[$];
  logic [11:0] dn_cnt_q[$];
  logic        dn_err_q[$];
  logic [31:0] mem [0:255];

  int n_chk = 0, n_fail = 0, n_done = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wb_word(input int cnt, input bit err);
    return (32'(cnt) << 16) | (32'(err) << 15);
  endfunction

  task automatic exp_rd(input logic [31:0] a, input string r);
    exp_q.push_back('{0, a, 32'h0, r});
  endtask

  // full fetch of an owned descriptor, offer if size non-zero, writeback
  task automatic exp_desc(input logic [31:0] a, input string r, input int cnt, input bit err);
    logic [31:0] w1 = mem[a[9:2] + 1];
    int sz = int'(w1[10:0]);
    exp_rd(a, r);
    exp_rd(a + 4, "R3");
    exp_rd(a + 8, "R3");
    exp_rd(a + 12, "R3");
    if (sz != 0) begin
      exp_q.push_back('{2, mem[a[9:2] + 2], 32'(sz), "R3"});
      dn_cnt_q.push_back(12'(cnt));
      dn_err_q.push_back(err);
      exp_q.push_back('{1, a, wb_word(cnt, err), "R4"});
    end else begin
      exp_q.push_back('{1, a, 32'h0, "R8"});
    end
  endtask

  function automatic item_t pop_exp();
    item_t it;
    if (exp_q.size() == 0) begin
      it = '{-1, 32'h0, 32'h0, "R3"};
    end else begin
      it = exp_q.pop_front();
    end
    return it;
  endfunction

  // memory responder, offer/done responder and scoreboard monitor
  initial begin
    bit pend = 0, last_we = 0, rdy = 0;
    int lat = 0, wcnt = 0, txn = 0, dtimer = 0;
    logic [31:0] h_addr = '0;
    logic h_we = 0;
    item_t it;
    forever begin
      @(negedge clk_i);
      if (done_i) done_i = 1'b0;
      if (dtimer > 0) begin
        dtimer--;
        if (dtimer == 0) begin
          done_count_i = dn_cnt_q.size() ? dn_cnt_q.pop_front() : 12'd0;
          done_err_i   = dn_err_q.size() ? dn_err_q.pop_front() : 1'b0;
          done_i = 1'b1;
        end
      end
      if (rdy) begin
        buf_ready_i = 1'b0;
        rdy = 0;
        dtimer = 3;
      end else if (buf_valid_o) begin
        it = pop_exp();
        chk(it.kind == 2 && buf_addr_o == it.addr, it.req, "offer address", buf_addr_o, it.addr);
        chk(32'(buf_size_o) == it.data, it.req, "offer size", 32'(buf_size_o), it.data);
        buf_ready_i = 1'b1;
        rdy = 1;
      end
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
        chk(desc_done_o == last_we, "R4", "desc_done after ack", 32'(desc_done_o), 32'(last_we));
        if (desc_done_o) n_done++;
      end else if (mem_req_o) begin
        if (!pend) begin
          pend = 1; h_addr = mem_addr_o; h_we = mem_we_o; wcnt = 0; lat = txn % 3;
        end
        if (wcnt == lat) begin
          chk(mem_addr_o == h_addr && mem_we_o == h_we, "R9", "held request", mem_addr_o, h_addr);
          it = pop_exp();
          chk(it.kind == int'(mem_we_o) && mem_addr_o == it.addr, it.req,
              mem_we_o ? "write address" : "read address", mem_addr_o, it.addr);
          if (mem_we_o) begin
            chk(mem_wdata_o == it.data, it.req, "write data", mem_wdata_o, it.data);
            mem[mem_addr_o[9:2]] = mem_wdata_o;
          end else begin
            mem_rdata_i = mem[mem_addr_o[9:2]];
          end
          last_we = mem_we_o;
          mem_ack_i = 1'b1;
          pend = 0;
          txn++;
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wait_parked();
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d pending items", exp_q.size(), 0);
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    // D0 0x100 chained to 0x140 (R6), D1 0x140 size 0 unchained (R8, R7),
    // D2 0x150 end of ring with chain set and link 0x200 (R5)
    mem[8'h40] = 32'h8000_0000; mem[8'h41] = (32'd1 << 24) | 32'd100;
    mem[8'h42] = 32'h0000_4000; mem[8'h43] = 32'h0000_0140;
    mem[8'h50] = 32'h8000_0000; mem[8'h51] = 32'h0000_0000;
    mem[8'h52] = 32'h0000_5000; mem[8'h53] = 32'h0000_0999;
    mem[8'h54] = 32'h8000_0000; mem[8'h55] = (32'd3 << 24) | 32'd1536;
    mem[8'h56] = 32'h0000_6000; mem[8'h57] = 32'h0000_0200;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!mem_req_o, "R1", "req after reset", 32'(mem_req_o), 0);
    chk(!buf_valid_o, "R1", "offer after reset", 32'(buf_valid_o), 0);
    chk(!idle_o && !desc_done_o, "R1", "idle/done after reset", 32'({idle_o, desc_done_o}), 0);
    repeat (5) @(negedge clk_i);
    chk(!mem_req_o, "R1", "no request before start", 32'(mem_req_o), 0);

    exp_desc(32'h100, "R1", 60, 1'b0);
    exp_desc(32'h140, "R6", 0, 1'b0);
    exp_desc(32'h150, "R7", 1536, 1'b1);
    exp_rd(32'h100, "R5 R10");
    base_addr_i = 32'h100;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    base_addr_i = 32'h300;
    @(negedge clk_i);
    start_i = 1'b1;  // R10: must be ignored while running
    @(negedge clk_i);
    start_i = 1'b0;

    wait_parked();
    chk(idle_o == 1'b1, "R2", "idle on host-owned", 32'(idle_o), 1);
    chk(!mem_req_o, "R2", "no request while parked", 32'(mem_req_o), 0);
    chk(n_done == 3, "R4", "writeback count", 32'(n_done), 3);
    chk(mem[8'h40] == 32'h003C_0000, "R4", "status word D0", mem[8'h40], 32'h003C_0000);

    repeat (6) @(negedge clk_i);
    chk(idle_o && !mem_req_o, "R2", "still parked without poll", 32'({idle_o, mem_req_o}), 32'h2);

    // give D0 back as end of ring, size 0, chain set with a bogus link
    mem[8'h40] = 32'h8000_0000;
    mem[8'h41] = 32'd3 << 24;
    mem[8'h43] = 32'h0000_0200;
    exp_desc(32'h100, "R2", 0, 1'b0);
    exp_rd(32'h100, "R5");
    poll_i = 1'b1;
    @(negedge clk_i);
    poll_i = 1'b0;

    wait_parked();
    chk(idle_o == 1'b1, "R2", "parked again", 32'(idle_o), 1);
    chk(n_done == 4, "R8", "zero-size writeback count", 32'(n_done), 4);
    chk(mem[8'h40] == 32'h0, "R8", "zero-size status", mem[8'h40], 32'h0);
    chk(exp_q.size() == 0, "R3", "scoreboard drained", 32'(exp_q.size()), 0);
    report();
  end
endmodule